// File: doc/BRIEF.md
# Preamble Quality Gate

This block judges whether the bit stream arriving at a receiver during a preamble looks like a real alternating preamble. It is not meant to pass noise. It keeps a small quality score and updates it on every strobed data bit. A bit that differs from the bit before it raises the score by one. A bit that repeats the bit before it lowers the score by eight, with a floor at zero. The score is compared against four times a 3-bit programmable level.

The block has two outputs. The quality flag drives a status bit and can be routed to a general-purpose pin. The sync gate tells the downstream sync-word correlator whether a match may be accepted. A level of zero turns the gate off, so that sync detection is always allowed. Each entry into the receive state is signalled by a one-cycle start pulse. That pulse clears the score and forgets the previous bit.

Top module: `pqe_gate`

## Requirements
- R1: A strobed bit that differs from the previously strobed bit raises the score by one.
- R2: A strobed bit equal to the previously strobed bit lowers the score by eight; a score below eight becomes zero.
- R3: The score saturates at 31; a transition at 31 leaves it at 31.
- R4: The first strobed bit after a receive-start pulse has no predecessor: it only records the bit and leaves the score unchanged.
- R5: `reached_o` is 1 exactly when the score is strictly greater than 4 × `thr_i` (thr_i is an unsigned 3-bit field, thresholds 0..28), and it follows a change of `thr_i` in the same cycle.
- R6: When `thr_i` is 0, `sync_en_o` is 1 regardless of the score.
- R7: When `thr_i` is nonzero, `sync_en_o` equals `reached_o`.
- R8: `rx_start_i` clears the score and the bit history on the next clock edge, and it wins over a bit strobe in the same cycle (that bit is discarded).
- R9: After asynchronous reset the score is 0 with no bit history, so `reached_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_start_i | input | 1 | One-cycle pulse on entry to the receive state |
| bit_valid_i | input | 1 | Strobe marking a recovered bit |
| bit_i | input | 1 | Recovered data bit |
| thr_i | input | 3 | Quality level; threshold is 4 × thr_i, 0 disables gating |
| reached_o | output | 1 | Score above threshold |
| sync_en_o | output | 1 | Permission for sync-word detection |

## Verification
The score can only be seen through `reached_o`. The bench therefore sweeps `thr_i` after a bit has been applied, which brackets the score between two adjacent multiples of four. A wrong step size, a missing floor or a missing saturation shows up as a flag on the wrong side of one of these brackets. The check comes one cycle after the offending strobe. A lost clear or a stale bit history shows up as an extra unit of score on the first bit after a start pulse, and the bench probes this with a threshold of zero.

// File: rtl/pqe_pkg.sv
package pqe_pkg;
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_FIRST  = 2'd1,
    EV_TOGGLE = 2'd2,
    EV_REPEAT = 2'd3
  } bit_ev_e;
endpackage

// File: rtl/pqe_bit_history.sv
module pqe_bit_history
  import pqe_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    clr_i,
  input  logic    valid_i,
  input  logic    bit_i,
  output bit_ev_e ev_o
);
  logic prev_q, have_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      have_q <= 1'b0;
    end else if (clr_i) begin
      prev_q <= 1'b0;
      have_q <= 1'b0;
    end else if (valid_i) begin
      prev_q <= bit_i;
      have_q <= 1'b1;
    end
  end

  always_comb begin
    if (clr_i || !valid_i) ev_o = EV_NONE;
    else if (!have_q)      ev_o = EV_FIRST;
    else if (bit_i == prev_q) ev_o = EV_REPEAT;
    else                   ev_o = EV_TOGGLE;
  end

  // R8: history forgotten after a clear
  a_r8_history_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) && valid_i && !clr_i |-> ev_o == EV_FIRST);
endmodule

// File: rtl/pqe_quality_cnt.sv
module pqe_quality_cnt
  import pqe_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int INC   = 1,
  parameter int DEC   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  bit_ev_e          ev_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] INC_V   = CNT_W'(INC);
  localparam logic [CNT_W-1:0] DEC_V   = CNT_W'(DEC);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_o;
    unique case (ev_i)
      EV_TOGGLE: cnt_d = (cnt_o > CNT_MAX - INC_V) ? CNT_MAX : cnt_o + INC_V;
      EV_REPEAT: cnt_d = (cnt_o < DEC_V) ? '0 : cnt_o - DEC_V;
      default:   cnt_d = cnt_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else             cnt_o <= cnt_d;
  end

  a_r1_toggle_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && ev_i == EV_TOGGLE && cnt_o < CNT_MAX |=> cnt_o == $past(cnt_o) + INC_V);
  a_r2_repeat_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && ev_i == EV_REPEAT |=>
      cnt_o == (($past(cnt_o) < DEC_V) ? '0 : $past(cnt_o) - DEC_V));
  a_r3_sat_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && ev_i == EV_TOGGLE && cnt_o == CNT_MAX |=> cnt_o == CNT_MAX);
  a_r4_first_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && ev_i == EV_FIRST |=> $stable(cnt_o));
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
endmodule

// File: rtl/pqe_threshold.sv
module pqe_threshold #(
  parameter int CNT_W = 5,
  parameter int THR_W = 3,
  parameter int SCALE = 4
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             reached_o,
  output logic             sync_en_o
);
  localparam int CMP_W = CNT_W + 1;

  logic [CMP_W-1:0] limit;

  assign limit     = CMP_W'(thr_i) * CMP_W'(SCALE);
  assign reached_o = CMP_W'(cnt_i) > limit;
  assign sync_en_o = (thr_i == '0) || reached_o;
endmodule

// File: rtl/pqe_gate.sv
module pqe_gate
  import pqe_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int THR_W = 3,
  parameter int SCALE = 4,
  parameter int INC   = 1,
  parameter int DEC   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_start_i,
  input  logic             bit_valid_i,
  input  logic             bit_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             reached_o,
  output logic             sync_en_o
);
  bit_ev_e          ev;
  logic [CNT_W-1:0] cnt;

  pqe_bit_history u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (rx_start_i),
    .valid_i (bit_valid_i),
    .bit_i   (bit_i),
    .ev_o    (ev)
  );

  pqe_quality_cnt #(.CNT_W(CNT_W), .INC(INC), .DEC(DEC)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rx_start_i),
    .ev_i   (ev),
    .cnt_o  (cnt)
  );

  pqe_threshold #(.CNT_W(CNT_W), .THR_W(THR_W), .SCALE(SCALE)) u_thr (
    .cnt_i     (cnt),
    .thr_i     (thr_i),
    .reached_o (reached_o),
    .sync_en_o (sync_en_o)
  );

  a_r6_gate_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_i == '0 |-> sync_en_o);
  a_r7_gate_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_i != '0 |-> sync_en_o == reached_o);
  a_r8_start_drops_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_start_i && thr_i != '0 |=> !sync_en_o || $changed(thr_i));
endmodule

// File: tb/pqe_gate_tb.sv
module pqe_gate_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_start = 1'b0;
  logic       bit_valid = 1'b0;
  logic       bit_v = 1'b0;
  logic [2:0] thr = 3'd0;
  logic       reached, sync_en;
  int         n_run = 0;
  int         n_fail = 0;

  always #10 clk = ~clk;

  pqe_gate u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .rx_start_i  (rx_start),
    .bit_valid_i (bit_valid),
    .bit_i       (bit_v),
    .thr_i       (thr),
    .reached_o   (reached),
    .sync_en_o   (sync_en)
  );

  // {rx_start, valid, bit, thr[2:0], exp_reached, exp_sync}
  localparam logic [7:0] VEC [12] = '{
    8'b1_0_0_001_0_0,  // clear
    8'b0_1_0_001_0_0,  // first bit, score 0
    8'b0_1_1_001_0_0,  // 1
    8'b0_1_0_001_0_0,  // 2
    8'b0_1_1_001_0_0,  // 3
    8'b0_1_0_001_0_0,  // 4, not above 4
    8'b0_1_1_001_1_1,  // 5
    8'b0_1_1_001_0_0,  // repeat: 5 -> 0
    8'b0_1_0_001_0_0,  // 1
    8'b0_1_1_001_0_0,  // 2
    8'b0_0_0_000_1_1,  // level 0: 2 > 0, gate off
    8'b0_0_0_111_0_0   // level 7
  };

  task automatic chk(input string tag, input logic got, input logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic step(input logic rs, input logic v, input logic b);
    @(negedge clk);
    rx_start = rs; bit_valid = v; bit_v = b;
    @(negedge clk);
    rx_start = 1'b0; bit_valid = 1'b0;
  endtask

  task automatic probe(input logic [2:0] t, input string tag, input logic exp_r);
    thr = t;
    #1;
    chk(tag, reached, exp_r);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #35;
    chk("R9 reset reached", reached, 1'b0);
    chk("R6 reset sync thr0", sync_en, 1'b1);
    rst_ni = 1'b1;

    // vector walk: R1 R2 R4 R5 R6 R7 R8
    for (int i = 0; i < 12; i++) begin
      thr = VEC[i][4:2];
      step(VEC[i][7], VEC[i][6], VEC[i][5]);
      chk($sformatf("R5 vec%0d reached", i), reached, VEC[i][1]);
      chk($sformatf("R7 vec%0d sync", i), sync_en, VEC[i][0]);
    end

    // R3: saturation at 31, then repeat -> 23
    step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 41; i++) step(1'b0, 1'b1, i[0]);
    probe(3'd7, "R3 saturated above 28", 1'b1);
    step(1'b0, 1'b1, 1'b0);  // last was 0 -> repeat
    probe(3'd5, "R2 31-8 above 20", 1'b1);
    probe(3'd6, "R3 31-8 not above 24", 1'b0);
    chk("R7 sync follows flag", sync_en, 1'b0);

    // R2: floor at zero
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b0);  // score 2
    step(1'b0, 1'b1, 1'b0);  // repeat -> 0
    probe(3'd0, "R2 floor zero", 1'b0);
    chk("R6 sync with gate off", sync_en, 1'b1);
    step(1'b0, 1'b1, 1'b1);
    probe(3'd0, "R1 inc from zero", 1'b1);

    // R8: start beats a simultaneous strobe
    step(1'b1, 1'b1, 1'b1);
    probe(3'd0, "R8 cleared", 1'b0);
    step(1'b0, 1'b1, 1'b0);  // must be first bit
    probe(3'd0, "R4 R8 bit dropped, first only", 1'b0);
    step(1'b0, 1'b1, 1'b1);
    probe(3'd0, "R1 next toggle", 1'b1);

    // R9: asynchronous reset mid-run
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, i[0]);
    probe(3'd1, "R5 before reset", 1'b1);
    #3 rst_ni = 1'b0;
    #1 chk("R9 async reset clears", reached, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    step(1'b0, 1'b1, 1'b1);
    probe(3'd0, "R9 R4 no history after reset", 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule